// File: doc/BRIEF.md
# Serial-bus channel buffer bank

This block is the register bank between an SPI slave front end and a serial sensor-bus master. It serves four buses with four channel buffers each. Every buffer holds an outgoing command, split into an upper and a lower byte. It also holds the last word returned by the bus and a read-only status byte. The front end presents one decoded byte access at a time while chip select is low. The block accepts writes, returns read data in the same cycle, and decides when a buffer's command counts as scheduled.

A command is scheduled when chip select is released, and only if the burst wrote both bytes of that buffer and raised no framing error. On a bus set to an 8-bit short word, the lower byte alone is enough. Two things cause a whole burst to be discarded: its first access names a status register, or it ends with a framing error. Scheduled buffers appear to the bus engine as pending, and each bus serves its lowest-numbered pending buffer first. The engine acknowledges a buffer with a one-cycle take pulse. Status seen by the host is frozen for the length of a burst, so a read never shows a partial update.

Top module: `chan_buf_bank`

## Requirements
- R1: After reset no bus requests service, and every status register reads 0x40: bit 7 is the CRC error flag (0) and bit 6 is the transmit-empty flag (1). All other bits read 0.
- R2: Writing the upper byte (address type 0) and the lower byte (type 1) of one buffer in a single burst, with no framing error, makes that buffer pending on the edge that first samples chip select high. The bus then presents the buffer index and the word {upper, lower}.
- R3: On a bus whose short-word input is 1, a burst that writes only the lower byte schedules the buffer, and the presented word is {0x00, lower}.
- R4: On a bus in normal word mode, writing only one of the two bytes in a burst schedules nothing, even when the other byte is written in a later burst.
- R5: A framing error at any point in a burst, or in the cycle chip select rises, cancels all scheduling for that burst.
- R6: If the first access of a burst addresses a status register (type 2), every write in that burst is ignored and nothing is scheduled. A later burst that starts with a data register schedules normally.
- R7: A scheduled buffer's transmit-empty flag reads 0 until the bus engine takes it, and reads 1 afterwards. A take pulse clears the bus request on the next edge.
- R8: While chip select stays low, status reads return the values captured before the burst, even if a take changes the flag during the burst. The new value is readable in the next burst.
- R9: A received word written by the bus engine reads back as upper byte (type 0) and lower byte (type 1). The CRC error flag (bit 7) takes the error input of every received word.
- R10: When several buffers on one bus are pending, the lowest-numbered one is presented first, and the next is presented after each take.
- R11: A per-channel clear pulse drops that channel's pending request on the next edge. It also returns its received data to 0 and its status to 0x40.

Address layout: bits [5:4] select the bus, bits [3:2] select the buffer, and bits [1:0] select the register type (0 upper, 1 lower, 2 status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select level, low during a burst |
| frame_err | input | 1 | Framing error seen in the current burst |
| acc_valid | input | 1 | One byte access this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | 6 | {bus, buffer, register type} |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, same cycle |
| short8 | input | 4 | Per bus: 8-bit short word mode |
| chan_clr | input | 16 | Per channel clear (channel = bus*4 + buffer) |
| tx_req | output | 4 | Per bus: a buffer is pending |
| tx_idx | output | 8 | Per bus: 2-bit index of served buffer |
| tx_word | output | 64 | Per bus: 16-bit word to send |
| tx_take | input | 4 | Per bus: engine takes the presented buffer |
| rx_valid | input | 4 | Per bus: received word valid |
| rx_idx | input | 8 | Per bus: 2-bit target buffer |
| rx_word | input | 64 | Per bus: 16-bit received word |
| rx_crc_err | input | 4 | Per bus: received CRC was wrong |

## Verification
Read data is combinational, so the monitor compares it on the falling edge of the same cycle that carries the read. A schedule becomes visible right after the edge that samples chip select high. The bench checks bus outputs just after that edge, and one edge after a take or clear pulse. Status is copied only while chip select is high, which puts a new flag at the second edge after release. The chip-select release task therefore always spends two edges before another burst begins.

// File: rtl/cbb_pkg.sv
// Shared types and constants for the channel buffer bank.
package cbb_pkg;
    // Register type carried in the two low address bits.
    typedef enum logic [1:0] {
        REG_HI   = 2'd0,
        REG_LO   = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int ER_BIT   = 7;
    localparam int TE_BIT   = 6;
    localparam logic [BYTE_W-1:0] STAT_RST = 8'h40;
endpackage

// File: rtl/cbb_burst.sv
// Burst tracker: finds the end of a burst from chip select and remembers,
// for the burst in progress, whether it must be ignored (first access hit a
// status register) and whether a framing error occurred.
// Assumes accesses are only presented while cs_n is low.
module cbb_burst
    import cbb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      frame_err,
    input  logic      acc_valid,
    input  reg_kind_e acc_kind,
    output logic      burst_end,
    output logic      commit_ok,
    output logic      acc_block
);
    logic cs_q;
    logic first_q;
    logic ign_q;
    logic ferr_q;
    logic ign_now;

    // Previous chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    assign burst_end = cs_n && !cs_q;
    assign ign_now   = ign_q || (first_q && acc_valid && acc_kind == REG_STAT);
    assign acc_block = ign_now;
    assign commit_ok = !ferr_q && !frame_err && !ign_q;

    // Marks that the next access is the first of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_q <= 1'b1;
        else if (cs_n)      first_q <= 1'b1;
        else if (acc_valid) first_q <= 1'b0;
    end

    // Holds the ignore decision for the rest of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)    ign_q <= 1'b0;
        else if (cs_n) ign_q <= 1'b0;
        else           ign_q <= ign_now;
    end

    // Accumulates framing errors over the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)    ferr_q <= 1'b0;
        else if (cs_n) ferr_q <= 1'b0;
        else           ferr_q <= ferr_q || frame_err;
    end
endmodule

// File: rtl/cbb_chan.sv
// One channel buffer: outgoing command bytes, the received word, the CRC
// error and transmit-empty flags, the pending request and the host-visible
// status copy that is refreshed only while chip select is high.
// Assumes write strobes are already gated by the burst tracker.
module cbb_chan
    import cbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cs_n,
    input  logic              burst_end,
    input  logic              commit_ok,
    input  logic              short8,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              take,
    input  logic              rx_we,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_err,
    output logic              pend,
    output logic [WORD_W-1:0] tx_word,
    output logic [BYTE_W-1:0] rd_hi,
    output logic [BYTE_W-1:0] rd_lo,
    output logic [BYTE_W-1:0] stat_vis
);
    logic [BYTE_W-1:0] tx_hi, tx_lo;
    logic              seen_hi, seen_lo;
    logic              te, er;
    logic              sched;
    logic [BYTE_W-1:0] stat_live;

    assign sched = burst_end && commit_ok && seen_lo && (seen_hi || short8);

    // Command byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tx_hi <= '0;
            tx_lo <= '0;
        end else begin
            if (wr_hi) tx_hi <= wdata;
            if (wr_lo) tx_lo <= wdata;
        end
    end

    // Remembers which bytes the current burst wrote.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || burst_end) begin
            seen_hi <= 1'b0;
            seen_lo <= 1'b0;
        end else begin
            if (wr_hi) seen_hi <= 1'b1;
            if (wr_lo) seen_lo <= 1'b1;
        end
    end

    // Pending request and transmit-empty flag; a new schedule beats a take.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend <= 1'b0;
            te   <= 1'b1;
        end else if (sched) begin
            pend <= 1'b1;
            te   <= 1'b0;
        end else if (take) begin
            pend <= 1'b0;
            te   <= 1'b1;
        end
    end

    // Received word and its CRC verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_hi <= '0;
            rd_lo <= '0;
            er    <= 1'b0;
        end else if (rx_we) begin
            rd_hi <= rx_word[WORD_W-1:BYTE_W];
            rd_lo <= rx_word[BYTE_W-1:0];
            er    <= rx_err;
        end
    end

    always_comb begin
        stat_live         = '0;
        stat_live[ER_BIT] = er;
        stat_live[TE_BIT] = te;
    end

    // Host-visible status, frozen while chip select is low.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) stat_vis <= STAT_RST;
        else if (cs_n)     stat_vis <= stat_live;
    end

    assign tx_word = short8 ? {{BYTE_W{1'b0}}, tx_lo} : {tx_hi, tx_lo};
endmodule

// File: rtl/cbb_arb.sv
// Per-bus selector: presents the lowest-numbered pending buffer and routes
// the engine's take pulse back to that buffer. Purely combinational.
module cbb_arb
    import cbb_pkg::*;
#(
    parameter  int NBUF = 4,
    localparam int BFW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0]        pend,
    input  logic [NBUF*WORD_W-1:0] words,
    input  logic                   take,
    output logic                   req,
    output logic [BFW-1:0]         idx,
    output logic [WORD_W-1:0]      word,
    output logic [NBUF-1:0]        take_vec
);
    // Fixed priority scan, lowest index wins.
    always_comb begin
        req = 1'b0;
        idx = '0;
        for (int k = NBUF - 1; k >= 0; k--) begin
            if (pend[k]) begin
                req = 1'b1;
                idx = BFW'(k);
            end
        end
    end

    assign word = words[idx*WORD_W +: WORD_W];

    // Routes the take pulse to the served buffer.
    always_comb begin
        take_vec = '0;
        if (take && req) take_vec[idx] = 1'b1;
    end
endmodule

// File: rtl/chan_buf_bank.sv
// Top of the channel buffer bank: decodes byte accesses, gates writes with
// the burst tracker, instantiates one buffer per bus/channel pair and one
// selector per bus, and muxes read data.
// Assumes NBUS and NBUF are powers of two and at least 2.
module chan_buf_bank
    import cbb_pkg::*;
#(
    parameter  int NBUS = 4,
    parameter  int NBUF = 4,
    localparam int BSW  = $clog2(NBUS),
    localparam int BFW  = $clog2(NBUF),
    localparam int CHW  = BSW + BFW,
    localparam int NCH  = NBUS * NBUF,
    localparam int AW   = CHW + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   frame_err,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [AW-1:0]          acc_addr,
    input  logic [BYTE_W-1:0]      acc_wdata,
    output logic [BYTE_W-1:0]      acc_rdata,
    input  logic [NBUS-1:0]        short8,
    input  logic [NCH-1:0]         chan_clr,
    output logic [NBUS-1:0]        tx_req,
    output logic [NBUS*BFW-1:0]    tx_idx,
    output logic [NBUS*WORD_W-1:0] tx_word,
    input  logic [NBUS-1:0]        tx_take,
    input  logic [NBUS-1:0]        rx_valid,
    input  logic [NBUS*BFW-1:0]    rx_idx,
    input  logic [NBUS*WORD_W-1:0] rx_word,
    input  logic [NBUS-1:0]        rx_crc_err
);
    reg_kind_e            kind;
    logic [CHW-1:0]       ach;
    logic                 burst_end, commit_ok, acc_block, wr_ok;
    logic [NCH-1:0]       pend_all, take_vec;
    logic [NCH*WORD_W-1:0] words_all;
    logic [NCH*BYTE_W-1:0] rdh_all, rdl_all, vis_all;

    assign kind  = reg_kind_e'(acc_addr[1:0]);
    assign ach   = acc_addr[AW-1:2];
    assign wr_ok = acc_valid && acc_write && !cs_n && !acc_block;

    cbb_burst u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .frame_err (frame_err),
        .acc_valid (acc_valid && !cs_n),
        .acc_kind  (kind),
        .burst_end (burst_end),
        .commit_ok (commit_ok),
        .acc_block (acc_block)
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        for (genvar k = 0; k < NBUF; k++) begin : g_buf
            localparam int CH = b * NBUF + k;
            logic sel;
            assign sel = (ach == CHW'(CH));
            cbb_chan u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (chan_clr[CH]),
                .cs_n      (cs_n),
                .burst_end (burst_end),
                .commit_ok (commit_ok),
                .short8    (short8[b]),
                .wr_hi     (wr_ok && sel && kind == REG_HI),
                .wr_lo     (wr_ok && sel && kind == REG_LO),
                .wdata     (acc_wdata),
                .take      (take_vec[CH]),
                .rx_we     (rx_valid[b] && rx_idx[b*BFW +: BFW] == BFW'(k)),
                .rx_word   (rx_word[b*WORD_W +: WORD_W]),
                .rx_err    (rx_crc_err[b]),
                .pend      (pend_all[CH]),
                .tx_word   (words_all[CH*WORD_W +: WORD_W]),
                .rd_hi     (rdh_all[CH*BYTE_W +: BYTE_W]),
                .rd_lo     (rdl_all[CH*BYTE_W +: BYTE_W]),
                .stat_vis  (vis_all[CH*BYTE_W +: BYTE_W])
            );
        end

        cbb_arb #(.NBUF(NBUF)) u_arb (
            .pend     (pend_all[b*NBUF +: NBUF]),
            .words    (words_all[b*NBUF*WORD_W +: NBUF*WORD_W]),
            .take     (tx_take[b]),
            .req      (tx_req[b]),
            .idx      (tx_idx[b*BFW +: BFW]),
            .word     (tx_word[b*WORD_W +: WORD_W]),
            .take_vec (take_vec[b*NBUF +: NBUF])
        );
    end

    // Read data selection by register type.
    always_comb begin
        case (kind)
            REG_HI:   acc_rdata = rdh_all[ach*BYTE_W +: BYTE_W];
            REG_LO:   acc_rdata = rdl_all[ach*BYTE_W +: BYTE_W];
            REG_STAT: acc_rdata = vis_all[ach*BYTE_W +: BYTE_W];
            default:  acc_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cbb_check.sv
// Property checker for chan_buf_bank, attached by bind.
module cbb_check #(
    parameter  int NBUS = 4,
    parameter  int NBUF = 4,
    localparam int BFW  = $clog2(NBUF),
    localparam int NCH  = NBUS * NBUF
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                burst_end,
    input logic                frame_err,
    input logic [NCH-1:0]      chan_clr,
    input logic [NCH-1:0]      pend,
    input logic [NCH*8-1:0]    vis,
    input logic [NBUS-1:0]     tx_req,
    input logic [NBUS*BFW-1:0] tx_idx
);
    assert_sched_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) != '0) |-> $past(burst_end));

    assert_ferr_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end && frame_err) |=> ((pend & ~$past(pend)) == '0));

    assert_status_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cs_n) && !$past(|chan_clr)) |-> $stable(vis));

    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_clr) |=> ((pend & $past(chan_clr)) == '0));

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        logic [NBUF-1:0] pb;
        logic [BFW-1:0]  ib;
        assign pb = pend[b*NBUF +: NBUF];
        assign ib = tx_idx[b*BFW +: BFW];

        assert_lowest_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
            tx_req[b] |-> (pb[ib] && ((pb & ((NBUF'(1) << ib) - NBUF'(1))) == '0)));

        assert_req_tracks_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_req[b] |-> (pb == '0));
    end
endmodule

bind chan_buf_bank cbb_check #(.NBUS(NBUS), .NBUF(NBUF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .burst_end (burst_end),
    .frame_err (frame_err),
    .chan_clr  (chan_clr),
    .pend      (pend_all),
    .vis       (vis_all),
    .tx_req    (tx_req),
    .tx_idx    (tx_idx)
);

// File: tb/sim_chan_buf_bank.sv
module sim_chan_buf_bank;
    localparam int NBUS = 4;
    localparam int NBUF = 4;
    localparam int BFW  = 2;
    localparam int NCH  = 16;
    localparam int AW   = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cs_n = 1'b1;
    logic                 frame_err = 1'b0;
    logic                 acc_valid = 1'b0;
    logic                 acc_write = 1'b0;
    logic [AW-1:0]        acc_addr = '0;
    logic [7:0]           acc_wdata = '0;
    logic [7:0]           acc_rdata;
    logic [NBUS-1:0]      short8 = '0;
    logic [NCH-1:0]       chan_clr = '0;
    logic [NBUS-1:0]      tx_req;
    logic [NBUS*BFW-1:0]  tx_idx;
    logic [NBUS*16-1:0]   tx_word;
    logic [NBUS-1:0]      tx_take = '0;
    logic [NBUS-1:0]      rx_valid = '0;
    logic [NBUS*BFW-1:0]  rx_idx = '0;
    logic [NBUS*16-1:0]   rx_word = '0;
    logic [NBUS-1:0]      rx_crc_err = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    chan_buf_bank u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .frame_err(frame_err),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .short8(short8),
        .chan_clr(chan_clr), .tx_req(tx_req), .tx_idx(tx_idx),
        .tx_word(tx_word), .tx_take(tx_take), .rx_valid(rx_valid),
        .rx_idx(rx_idx), .rx_word(rx_word), .rx_crc_err(rx_crc_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] ad(int b, int k, int t);
        return {b[1:0], k[1:0], t[1:0]};
    endfunction

    task automatic wr(int b, int k, int t, logic [7:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = ad(b, k, t); acc_wdata = d;
        tick();
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Driver: queues the expected byte, then issues the read.
    task automatic rd(int b, int k, int t, logic [7:0] e, int req);
        exp_q.push_back({req[7:0], e});
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = ad(b, k, t);
        tick();
        acc_valid = 1'b0;
    endtask

    // Monitor: read data is combinational, compared mid-cycle.
    always @(negedge clk) begin
        if (acc_valid && !acc_write) begin
            logic [15:0] it;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R0 unexpected read got %h exp none", acc_rdata);
            end else begin
                it = exp_q.pop_front();
                if (acc_rdata !== it[7:0]) begin
                    errors++;
                    $display("FAIL R%0d read addr %h got %h exp %h",
                             it[15:8], acc_addr, acc_rdata, it[7:0]);
                end
            end
        end
    end

    task automatic chk(int req, string what, logic [31:0] act, logic [31:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL R%0d %s got %h exp %h", req, what, act, e);
        end
    endtask

    task automatic bus_chk(int b, bit r, int i, logic [15:0] w, int req);
        chk(req, "tx_req", 32'(tx_req[b]), 32'(r));
        if (r) begin
            chk(req, "tx_idx", 32'(tx_idx[b*BFW +: BFW]), 32'(i));
            chk(req, "tx_word", 32'(tx_word[b*16 +: 16]), 32'(w));
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick();
    endtask

    // Release: commit on the first edge, status copy on the second.
    task automatic cs_hi();
        cs_n = 1'b1;
        tick();
        tick();
    endtask

    task automatic take(int b);
        tx_take[b] = 1'b1;
        tick();
        tx_take[b] = 1'b0;
    endtask

    task automatic rx(int b, int k, logic [15:0] w, bit e);
        rx_valid[b] = 1'b1; rx_idx[b*BFW +: BFW] = k[1:0];
        rx_word[b*16 +: 16] = w; rx_crc_err[b] = e;
        tick();
        rx_valid[b] = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk(1, "tx_req after reset", 32'(tx_req), 32'h0);
        cs_lo(); rd(0, 0, 2, 8'h40, 1); rd(3, 3, 2, 8'h40, 1); cs_hi();

        // R2: full pair schedules
        cs_lo(); wr(0, 1, 0, 8'h12); wr(0, 1, 1, 8'h34); cs_hi();
        bus_chk(0, 1, 1, 16'h1234, 2);

        // R7: empty flag low until taken
        cs_lo(); rd(0, 1, 2, 8'h00, 7); cs_hi();
        take(0);
        chk(7, "tx_req after take", 32'(tx_req[0]), 32'h0);
        tick();
        cs_lo(); rd(0, 1, 2, 8'h40, 7); cs_hi();

        // R8: status frozen during a burst
        cs_lo(); wr(1, 0, 0, 8'hAB); wr(1, 0, 1, 8'hCD); cs_hi();
        bus_chk(1, 1, 0, 16'hABCD, 8);
        cs_lo(); take(1);
        rd(1, 0, 2, 8'h00, 8);
        chk(8, "tx_req after take in burst", 32'(tx_req[1]), 32'h0);
        cs_hi();
        cs_lo(); rd(1, 0, 2, 8'h40, 8); cs_hi();

        // R10: lowest pending first
        cs_lo(); wr(2, 3, 0, 8'h33); wr(2, 3, 1, 8'h44);
        wr(2, 1, 0, 8'h11); wr(2, 1, 1, 8'h22); cs_hi();
        bus_chk(2, 1, 1, 16'h1122, 10);
        take(2);
        bus_chk(2, 1, 3, 16'h3344, 10);
        take(2);
        bus_chk(2, 0, 0, 16'h0, 10);

        // R3: short word, low byte only
        short8[3] = 1'b1;
        cs_lo(); wr(3, 2, 1, 8'hA5); cs_hi();
        bus_chk(3, 1, 2, 16'h00A5, 3);
        take(3);

        // R4: single byte does not schedule, across bursts either
        cs_lo(); wr(0, 2, 0, 8'h55); cs_hi();
        bus_chk(0, 0, 0, 16'h0, 4);
        cs_lo(); wr(0, 2, 1, 8'h66); cs_hi();
        bus_chk(0, 0, 0, 16'h0, 4);
        cs_lo(); rd(0, 2, 2, 8'h40, 4); cs_hi();

        // R5: framing error cancels
        cs_lo(); wr(0, 3, 0, 8'h77);
        frame_err = 1'b1; tick(); frame_err = 1'b0;
        wr(0, 3, 1, 8'h88); cs_hi();
        bus_chk(0, 0, 0, 16'h0, 5);
        cs_lo(); wr(0, 3, 0, 8'h79); wr(0, 3, 1, 8'h89);
        cs_n = 1'b1; frame_err = 1'b1; tick(); frame_err = 1'b0; tick();
        bus_chk(0, 0, 0, 16'h0, 5);

        // R6: burst starting at a status register is ignored
        cs_lo(); rd(0, 0, 2, 8'h40, 6); wr(0, 0, 0, 8'h99); wr(0, 0, 1, 8'h9A); cs_hi();
        bus_chk(0, 0, 0, 16'h0, 6);
        cs_lo(); wr(0, 0, 0, 8'h01); wr(0, 0, 1, 8'h02); cs_hi();
        bus_chk(0, 1, 0, 16'h0102, 6);
        take(0); tick();

        // R9: received word and CRC flag
        rx(1, 2, 16'hBEEF, 1'b1);
        cs_lo(); rd(1, 2, 0, 8'hBE, 9); rd(1, 2, 1, 8'hEF, 9); rd(1, 2, 2, 8'hC0, 9); cs_hi();
        rx(1, 2, 16'h0102, 1'b0);
        cs_lo(); rd(1, 2, 2, 8'h40, 9); rd(1, 2, 1, 8'h02, 9); cs_hi();

        // R11: channel clear
        cs_lo(); wr(1, 2, 0, 8'h5A); wr(1, 2, 1, 8'hA5); cs_hi();
        bus_chk(1, 1, 2, 16'h5AA5, 11);
        chan_clr[6] = 1'b1; tick(); chan_clr[6] = 1'b0;
        chk(11, "tx_req after clear", 32'(tx_req[1]), 32'h0);
        tick();
        cs_lo(); rd(1, 2, 0, 8'h00, 11); rd(1, 2, 2, 8'h40, 11); cs_hi();

        tick();
        chk(0, "pending reads left", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R0 watchdog got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule